// File: doc/BRIEF.md
# Inclusive Two-Level Translation Buffer Controller

This block manages a two-level address translation cache. Instruction fetches and data accesses each have their own small, fully associative first-level buffer. Both sit in front of one shared second-level buffer. Each lookup port takes a virtual page number and an address-space bit and returns a hit flag with the physical page, or a miss flag.

Software installs translations through a write-entry port. The port names a second-level slot and carries the new contents. A write changes only the second level. Before the slot is overwritten, its current occupant is read out and its page number and address-space bit go to both first-level buffers. Any matching copy there is dropped, so every first-level entry always also lives in the second level. First-level buffers are filled only by hardware. When a lookup misses in its first-level buffer but hits in the second level, the entry is copied in. Slots are chosen round-robin.

Lookup requests use valid/ready. A request is taken when `*_lk_valid` and `*_lk_ready` are both high. Ready drops for exactly one cycle after a request that needs the second level, while the copy is made. Responses carry no back-pressure: `*_rsp_valid` is high for one cycle and the consumer must take it then. The write-entry port has no ready and accepts a command in every cycle that `wr_valid` is high.

Top module: `xlat_hier_ctrl`

## Requirements
- R1: After reset every entry at both levels is invalid, both `*_lk_ready` outputs are high and neither `*_rsp_valid` is asserted.
- R2: A second-level entry matches a lookup only when it is valid and both its page number and its address-space bit equal the request's. A different address-space bit gives a miss.
- R3: A write command stores valid flag, page, space bit and physical page into second-level slot `wr_idx` at the clock edge that accepts it. It never places an entry in either first-level buffer, so the first lookup of a newly written page takes the second-level path.
- R4: If the slot overwritten by a write holds a valid entry, every first-level entry in both buffers with that entry's page and space bit is invalidated at the same edge.
- R5: A lookup that misses in its first level and hits in the second level gets `rsp_hit`=1 with the physical page two cycles after acceptance. Ready is low in the cycle between, and the entry is copied into that port's first level.
- R6: A lookup that hits in its first level gets `rsp_hit`=1 with the physical page one cycle after acceptance.
- R7: A lookup that misses in both levels gets `rsp_miss`=1, `rsp_hit`=0 and physical page 0 one cycle after acceptance, and changes neither level.
- R8: Each first-level buffer fills its slots in round-robin order 0,1,2,3,0,… The pointer advances only when a copy is actually made, so with four slots the fifth distinct page evicts the first one copied.
- R9: A copy is dropped if a write's victim has the same page and space bit as the pending copy. This applies to a write in the acceptance cycle or in the copy cycle. The response still reports a hit with the physical page read at acceptance.
- R10: The instruction and data ports are independent: a copy into one first-level buffer does not make the other port hit in its first level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_lk_valid | input | 1 | Instruction lookup request valid |
| ins_lk_ready | output | 1 | Instruction lookup request ready |
| ins_lk_epn | input | EPN_W | Instruction lookup virtual page number |
| ins_lk_as | input | 1 | Instruction lookup address-space bit |
| ins_rsp_valid | output | 1 | Instruction response valid |
| ins_rsp_hit | output | 1 | Instruction response: translation found |
| ins_rsp_miss | output | 1 | Instruction response: missed both levels |
| ins_rsp_rpn | output | RPN_W | Instruction response physical page |
| dat_lk_valid | input | 1 | Data lookup request valid |
| dat_lk_ready | output | 1 | Data lookup request ready |
| dat_lk_epn | input | EPN_W | Data lookup virtual page number |
| dat_lk_as | input | 1 | Data lookup address-space bit |
| dat_rsp_valid | output | 1 | Data response valid |
| dat_rsp_hit | output | 1 | Data response: translation found |
| dat_rsp_miss | output | 1 | Data response: missed both levels |
| dat_rsp_rpn | output | RPN_W | Data response physical page |
| wr_valid | input | 1 | Write-entry command valid |
| wr_idx | input | log2(L2_DEPTH) | Second-level slot to overwrite |
| wr_ent_vld | input | 1 | Valid flag of the new entry |
| wr_epn | input | EPN_W | Page number of the new entry |
| wr_as | input | 1 | Address-space bit of the new entry |
| wr_rpn | input | RPN_W | Physical page of the new entry |

## Verification
The bench uses the default parameters: four first-level slots per port, sixteen second-level slots and 20-bit page numbers. Four slots let five distinct pages wrap the round-robin pointer in a few lookups. Sixteen slots leave room to hold the same page in two second-level slots. That makes back-invalidation visible: after one copy is overwritten the page still translates, but only through the slower second-level path. Response latency tells first-level residency apart from a second-level hit, so the bench can observe every fill, eviction and dropped copy at the ports.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_e;
endpackage

// File: rtl/xlat_l2_array.sv
module xlat_l2_array #(
  parameter int EPN_W = 20,
  parameter int RPN_W = 20,
  parameter int DEPTH = 16,
  parameter int NPORT = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0][EPN_W-1:0] q_epn,
  input  logic [NPORT-1:0]            q_as,
  output logic [NPORT-1:0]            q_hit,
  output logic [NPORT-1:0][RPN_W-1:0] q_rpn,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic                        wr_vld,
  input  logic [EPN_W-1:0]            wr_epn,
  input  logic                        wr_as,
  input  logic [RPN_W-1:0]            wr_rpn,
  output logic                        vic_vld,
  output logic [EPN_W-1:0]            vic_epn,
  output logic                        vic_as
);
  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] as_q;
  logic [EPN_W-1:0] epn_q [DEPTH];
  logic [RPN_W-1:0] rpn_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q  <= '0;
      as_q <= '0;
      for (int e = 0; e < DEPTH; e++) begin
        epn_q[e] <= '0;
        rpn_q[e] <= '0;
      end
    end else if (wr_en) begin
      v_q[wr_idx]   <= wr_vld;
      as_q[wr_idx]  <= wr_as;
      epn_q[wr_idx] <= wr_epn;
      rpn_q[wr_idx] <= wr_rpn;
    end
  end

  // victim read happens in the same cycle as the write command
  assign vic_vld = wr_en && v_q[wr_idx];
  assign vic_epn = epn_q[wr_idx];
  assign vic_as  = as_q[wr_idx];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic             hit_l;
    logic [RPN_W-1:0] rpn_l;
    always_comb begin
      hit_l = 1'b0;
      rpn_l = '0;
      for (int e = 0; e < DEPTH; e++) begin
        if (!hit_l && v_q[e] && epn_q[e] == q_epn[p] && as_q[e] == q_as[p]) begin
          hit_l = 1'b1;
          rpn_l = rpn_q[e];
        end
      end
    end
    assign q_hit[p] = hit_l;
    assign q_rpn[p] = rpn_l;
  end

  // R3
  l2_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> v_q[$past(wr_idx)] == $past(wr_vld) && epn_q[$past(wr_idx)] == $past(wr_epn)
              && rpn_q[$past(wr_idx)] == $past(wr_rpn));
endmodule

// File: rtl/xlat_l1_port.sv
module xlat_l1_port
  import xlat_pkg::*;
#(
  parameter int EPN_W = 20,
  parameter int RPN_W = 20,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_valid,
  output logic             lk_ready,
  input  logic [EPN_W-1:0] lk_epn,
  input  logic             lk_as,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_miss,
  output logic [RPN_W-1:0] rsp_rpn,
  input  logic             l2_hit,
  input  logic [RPN_W-1:0] l2_rpn,
  input  logic             inv_en,
  input  logic [EPN_W-1:0] inv_epn,
  input  logic             inv_as
);
  logic [DEPTH-1:0] v_q, v_nxt, hit_vec, inv_vec;
  logic [DEPTH-1:0] as_q;
  logic [EPN_W-1:0] epn_q [DEPTH];
  logic [RPN_W-1:0] rpn_q [DEPTH];
  logic [PTR_W-1:0] rr_q;
  fill_e            st_q;
  logic             kill_q;
  logic [EPN_W-1:0] pend_epn_q;
  logic             pend_as_q;
  logic [RPN_W-1:0] pend_rpn_q;
  logic             acc, l1_hit, kill_now, kill_acc, commit;
  logic [RPN_W-1:0] l1_rpn;

  assign lk_ready = (st_q == FILL_IDLE);
  assign acc      = lk_valid && lk_ready;

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign hit_vec[k] = v_q[k] && epn_q[k] == lk_epn && as_q[k] == lk_as;
    assign inv_vec[k] = inv_en && v_q[k] && epn_q[k] == inv_epn && as_q[k] == inv_as;
    // R4
    back_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
      inv_vec[k] |=> !v_q[k] || epn_q[k] != $past(inv_epn) || as_q[k] != $past(inv_as));
  end

  always_comb begin
    l1_rpn = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (hit_vec[k]) l1_rpn = l1_rpn | rpn_q[k];
    end
  end
  assign l1_hit = |hit_vec;

  // write victim equals the page being looked up now: the second-level read is stale
  assign kill_acc = inv_en && inv_epn == lk_epn && inv_as == lk_as;
  // write victim equals the page held for copying in this cycle
  assign kill_now = inv_en && inv_epn == pend_epn_q && inv_as == pend_as_q;
  assign commit   = (st_q == FILL_BUSY) && !kill_q && !kill_now;

  always_comb begin
    v_nxt = v_q & ~inv_vec;
    if (commit) v_nxt[rr_q] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q        <= '0;
      as_q       <= '0;
      rr_q       <= '0;
      st_q       <= FILL_IDLE;
      kill_q     <= 1'b0;
      pend_epn_q <= '0;
      pend_as_q  <= 1'b0;
      pend_rpn_q <= '0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_miss   <= 1'b0;
      rsp_rpn    <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        epn_q[k] <= '0;
        rpn_q[k] <= '0;
      end
    end else begin
      v_q       <= v_nxt;
      rsp_valid <= 1'b0;
      if (commit) begin
        as_q[rr_q]  <= pend_as_q;
        epn_q[rr_q] <= pend_epn_q;
        rpn_q[rr_q] <= pend_rpn_q;
        rr_q        <= (rr_q == PTR_W'(DEPTH - 1)) ? '0 : rr_q + PTR_W'(1);
      end
      if (st_q == FILL_BUSY) begin
        st_q      <= FILL_IDLE;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_miss  <= 1'b0;
        rsp_rpn   <= pend_rpn_q;
      end else if (acc) begin
        if (!l1_hit && l2_hit) begin
          st_q       <= FILL_BUSY;
          kill_q     <= kill_acc;
          pend_epn_q <= lk_epn;
          pend_as_q  <= lk_as;
          pend_rpn_q <= l2_rpn;
        end else begin
          rsp_valid <= 1'b1;
          rsp_hit   <= l1_hit;
          rsp_miss  <= !l1_hit;
          rsp_rpn   <= l1_hit ? l1_rpn : '0;
        end
      end
    end
  end

  // R5
  accept_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid || !lk_ready);
  // R5
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_ready |=> rsp_valid && rsp_hit && lk_ready);
  // R7
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_hit != rsp_miss);
  // R3
  no_write_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_ready) |-> $countones(v_q) <= $countones($past(v_q)));
endmodule

// File: rtl/xlat_hier_ctrl.sv
module xlat_hier_ctrl #(
  parameter int EPN_W    = 20,
  parameter int RPN_W    = 20,
  parameter int L1_DEPTH = 4,
  parameter int L2_DEPTH = 16,
  localparam int IDX_W   = $clog2(L2_DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ins_lk_valid,
  output logic             ins_lk_ready,
  input  logic [EPN_W-1:0] ins_lk_epn,
  input  logic             ins_lk_as,
  output logic             ins_rsp_valid,
  output logic             ins_rsp_hit,
  output logic             ins_rsp_miss,
  output logic [RPN_W-1:0] ins_rsp_rpn,
  input  logic             dat_lk_valid,
  output logic             dat_lk_ready,
  input  logic [EPN_W-1:0] dat_lk_epn,
  input  logic             dat_lk_as,
  output logic             dat_rsp_valid,
  output logic             dat_rsp_hit,
  output logic             dat_rsp_miss,
  output logic [RPN_W-1:0] dat_rsp_rpn,
  input  logic             wr_valid,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_ent_vld,
  input  logic [EPN_W-1:0] wr_epn,
  input  logic             wr_as,
  input  logic [RPN_W-1:0] wr_rpn
);
  logic [1:0][EPN_W-1:0] q_epn;
  logic [1:0]            q_as, q_hit;
  logic [1:0][RPN_W-1:0] q_rpn;
  logic                  vic_vld, vic_as;
  logic [EPN_W-1:0]      vic_epn;

  assign q_epn = {dat_lk_epn, ins_lk_epn};
  assign q_as  = {dat_lk_as, ins_lk_as};

  xlat_l2_array #(.EPN_W(EPN_W), .RPN_W(RPN_W), .DEPTH(L2_DEPTH), .NPORT(2)) u_l2 (
    .clk(clk), .rst_n(rst_n),
    .q_epn(q_epn), .q_as(q_as), .q_hit(q_hit), .q_rpn(q_rpn),
    .wr_en(wr_valid), .wr_idx(wr_idx), .wr_vld(wr_ent_vld),
    .wr_epn(wr_epn), .wr_as(wr_as), .wr_rpn(wr_rpn),
    .vic_vld(vic_vld), .vic_epn(vic_epn), .vic_as(vic_as)
  );

  xlat_l1_port #(.EPN_W(EPN_W), .RPN_W(RPN_W), .DEPTH(L1_DEPTH)) u_ins (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(ins_lk_valid), .lk_ready(ins_lk_ready), .lk_epn(ins_lk_epn), .lk_as(ins_lk_as),
    .rsp_valid(ins_rsp_valid), .rsp_hit(ins_rsp_hit), .rsp_miss(ins_rsp_miss), .rsp_rpn(ins_rsp_rpn),
    .l2_hit(q_hit[0]), .l2_rpn(q_rpn[0]),
    .inv_en(vic_vld), .inv_epn(vic_epn), .inv_as(vic_as)
  );

  xlat_l1_port #(.EPN_W(EPN_W), .RPN_W(RPN_W), .DEPTH(L1_DEPTH)) u_dat (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(dat_lk_valid), .lk_ready(dat_lk_ready), .lk_epn(dat_lk_epn), .lk_as(dat_lk_as),
    .rsp_valid(dat_rsp_valid), .rsp_hit(dat_rsp_hit), .rsp_miss(dat_rsp_miss), .rsp_rpn(dat_rsp_rpn),
    .l2_hit(q_hit[1]), .l2_rpn(q_rpn[1]),
    .inv_en(vic_vld), .inv_epn(vic_epn), .inv_as(vic_as)
  );
endmodule

// File: tb/test_xlat_hier_ctrl.sv
module test_xlat_hier_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ins_lk_valid, ins_lk_ready, ins_lk_as;
  logic [19:0] ins_lk_epn, ins_rsp_rpn;
  logic        ins_rsp_valid, ins_rsp_hit, ins_rsp_miss;
  logic        dat_lk_valid, dat_lk_ready, dat_lk_as;
  logic [19:0] dat_lk_epn, dat_rsp_rpn;
  logic        dat_rsp_valid, dat_rsp_hit, dat_rsp_miss;
  logic        wr_valid, wr_ent_vld, wr_as;
  logic [3:0]  wr_idx;
  logic [19:0] wr_epn, wr_rpn;

  int n_run  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  xlat_hier_ctrl i_xlat_hier_ctrl (.*);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ins_lk_valid = 0; ins_lk_epn = '0; ins_lk_as = 0;
    dat_lk_valid = 0; dat_lk_epn = '0; dat_lk_as = 0;
    wr_valid = 0; wr_idx = '0; wr_ent_vld = 0; wr_epn = '0; wr_as = 0; wr_rpn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic write_ent(input logic [3:0] idx, input logic vld, input logic [19:0] epn,
                           input logic as, input logic [19:0] rpn);
    @(negedge clk);
    wr_valid = 1; wr_idx = idx; wr_ent_vld = vld; wr_epn = epn; wr_as = as; wr_rpn = rpn;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic lookup(input bit port, input logic [19:0] epn, input logic as,
                        output int lat, output logic hit, output logic miss,
                        output logic [19:0] rpn, output logic rdy_mid);
    @(negedge clk);
    if (port) begin dat_lk_valid = 1; dat_lk_epn = epn; dat_lk_as = as; end
    else      begin ins_lk_valid = 1; ins_lk_epn = epn; ins_lk_as = as; end
    @(negedge clk);
    ins_lk_valid = 0; dat_lk_valid = 0;
    lat = 1; rdy_mid = 1'b1;
    while (!(port ? dat_rsp_valid : ins_rsp_valid) && lat < 3) begin
      rdy_mid = port ? dat_lk_ready : ins_lk_ready;
      @(negedge clk);
      lat++;
    end
    hit  = port ? dat_rsp_hit  : ins_rsp_hit;
    miss = port ? dat_rsp_miss : ins_rsp_miss;
    rpn  = port ? dat_rsp_rpn  : ins_rsp_rpn;
  endtask

  task automatic expect_lk(input string req, input bit port, input logic [19:0] epn, input logic as,
                           input int exp_lat, input logic exp_hit, input logic [19:0] exp_rpn);
    int lat; logic hit, miss, rdy; logic [19:0] rpn;
    lookup(port, epn, as, lat, hit, miss, rpn, rdy);
    chk(req, $sformatf("latency page %0h", epn), lat, exp_lat);
    chk(req, "hit", {31'd0, hit}, {31'd0, exp_hit});
    chk(req, "miss", {31'd0, miss}, {31'd0, !exp_hit});
    chk(req, "rpn", {12'd0, rpn}, {12'd0, exp_rpn});
    if (exp_lat == 2) chk(req, "ready low during copy", {31'd0, rdy}, 32'd0);
  endtask

  // R1
  task automatic t_reset();
    do_reset();
    chk("R1", "ins ready", {31'd0, ins_lk_ready}, 1);
    chk("R1", "dat ready", {31'd0, dat_lk_ready}, 1);
    chk("R1", "ins rsp_valid", {31'd0, ins_rsp_valid}, 0);
    chk("R1", "dat rsp_valid", {31'd0, dat_rsp_valid}, 0);
    expect_lk("R1", 0, 20'h0, 1'b0, 1, 1'b0, 20'h0);
  endtask

  // R8 round robin over four slots
  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 5; i++) write_ent(4'(8 + i), 1'b1, 20'h100 + 20'(i), 1'b0, 20'hA00 + 20'(i));
    for (int i = 0; i < 5; i++) expect_lk("R8", 0, 20'h100 + 20'(i), 1'b0, 2, 1'b1, 20'hA00 + 20'(i));
    expect_lk("R8", 0, 20'h104, 1'b0, 1, 1'b1, 20'hA04);
    expect_lk("R8", 0, 20'h101, 1'b0, 1, 1'b1, 20'hA01);
    expect_lk("R8", 0, 20'h100, 1'b0, 2, 1'b1, 20'hA00);
    expect_lk("R8", 0, 20'h101, 1'b0, 2, 1'b1, 20'hA01);
    expect_lk("R8", 0, 20'h103, 1'b0, 1, 1'b1, 20'hA03);
  endtask

  // R7
  task automatic t_miss();
    do_reset();
    write_ent(4'd2, 1'b1, 20'h222, 1'b0, 20'h5222);
    expect_lk("R7", 0, 20'h777, 1'b0, 1, 1'b0, 20'h0);
    expect_lk("R7", 0, 20'h777, 1'b0, 1, 1'b0, 20'h0);
    expect_lk("R7", 1, 20'h777, 1'b1, 1, 1'b0, 20'h0);
    expect_lk("R7", 0, 20'h222, 1'b0, 2, 1'b1, 20'h5222);
  endtask

  // R3, R5, R6, R10, R2
  task automatic t_fill_path();
    do_reset();
    write_ent(4'd3, 1'b1, 20'hABC, 1'b0, 20'h1234);
    expect_lk("R3", 0, 20'hABC, 1'b0, 2, 1'b1, 20'h1234);
    expect_lk("R6", 0, 20'hABC, 1'b0, 1, 1'b1, 20'h1234);
    expect_lk("R10", 1, 20'hABC, 1'b0, 2, 1'b1, 20'h1234);
    expect_lk("R5", 1, 20'hABC, 1'b0, 1, 1'b1, 20'h1234);
    expect_lk("R2", 0, 20'hABC, 1'b1, 1, 1'b0, 20'h0);
    write_ent(4'd4, 1'b0, 20'hDEF, 1'b0, 20'h4444);
    expect_lk("R2", 1, 20'hDEF, 1'b0, 1, 1'b0, 20'h0);
  endtask

  // R4: page kept in two slots; overwriting one removes first-level copies
  task automatic t_back_inval();
    do_reset();
    write_ent(4'd3, 1'b1, 20'hA0, 1'b0, 20'h9A0);
    write_ent(4'd5, 1'b1, 20'hA0, 1'b0, 20'h9A0);
    expect_lk("R4", 0, 20'hA0, 1'b0, 2, 1'b1, 20'h9A0);
    expect_lk("R4", 1, 20'hA0, 1'b0, 2, 1'b1, 20'h9A0);
    expect_lk("R4", 0, 20'hA0, 1'b0, 1, 1'b1, 20'h9A0);
    write_ent(4'd3, 1'b1, 20'hB0, 1'b0, 20'h9B0);
    expect_lk("R4", 0, 20'hA0, 1'b0, 2, 1'b1, 20'h9A0);
    expect_lk("R4", 1, 20'hA0, 1'b0, 2, 1'b1, 20'h9A0);
    expect_lk("R4", 0, 20'hB0, 1'b0, 2, 1'b1, 20'h9B0);
  endtask

  // R9: write victim matches the pending copy in the copy cycle
  task automatic t_conflict_fill_cycle();
    do_reset();
    write_ent(4'd7, 1'b1, 20'hC0, 1'b0, 20'h7C0);
    @(negedge clk);
    ins_lk_valid = 1; ins_lk_epn = 20'hC0; ins_lk_as = 0;
    @(negedge clk);
    ins_lk_valid = 0;
    wr_valid = 1; wr_idx = 4'd7; wr_ent_vld = 1; wr_epn = 20'hD0; wr_as = 0; wr_rpn = 20'h7D0;
    @(negedge clk);
    wr_valid = 0;
    chk("R9", "copy-cycle rsp_valid", {31'd0, ins_rsp_valid}, 1);
    chk("R9", "copy-cycle rsp_hit", {31'd0, ins_rsp_hit}, 1);
    chk("R9", "copy-cycle rpn", {12'd0, ins_rsp_rpn}, {12'd0, 20'h7C0});
    expect_lk("R9", 0, 20'hC0, 1'b0, 1, 1'b0, 20'h0);
    expect_lk("R9", 0, 20'hD0, 1'b0, 2, 1'b1, 20'h7D0);
  endtask

  // R9: write victim matches the lookup in its acceptance cycle
  task automatic t_conflict_accept_cycle();
    do_reset();
    write_ent(4'd6, 1'b1, 20'hE0, 1'b1, 20'h6E0);
    @(negedge clk);
    ins_lk_valid = 1; ins_lk_epn = 20'hE0; ins_lk_as = 1;
    wr_valid = 1; wr_idx = 4'd6; wr_ent_vld = 1; wr_epn = 20'hF0; wr_as = 1; wr_rpn = 20'h6F0;
    @(negedge clk);
    ins_lk_valid = 0; wr_valid = 0;
    chk("R9", "accept-cycle no early rsp", {31'd0, ins_rsp_valid}, 0);
    @(negedge clk);
    chk("R9", "accept-cycle rsp_hit", {31'd0, ins_rsp_valid & ins_rsp_hit}, 1);
    chk("R9", "accept-cycle rpn", {12'd0, ins_rsp_rpn}, {12'd0, 20'h6E0});
    expect_lk("R9", 0, 20'hE0, 1'b1, 1, 1'b0, 20'h0);
  endtask

  initial begin
    t_reset();
    t_round_robin();
    t_miss();
    t_fill_path();
    t_back_inval();
    t_conflict_fill_cycle();
    t_conflict_accept_cycle();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule